// File: doc/BRIEF.md
# SAR ADC conversion timing sequencer

This block is the digital sequencer for one successive-approximation conversion. A single-cycle start request, together with a two-bit final-sample-length code and an amplifier-bypass flag, launches a conversion. The sequencer then runs three phases in fixed order. First, the sample buffer amplifier charges the sample capacitor. Second, the input charges the capacitor array directly. Third, a ten-step resolution fills the successive-approximation register.

All phase timing counts pulses of a one-cycle conversion-clock enable. That enable comes from a prescaler outside the block, so one conversion-clock period may span many system clocks. The block drives the buffer-enable and direct-sample strobes and the trial code for the capacitor-array DAC. It reads a comparator that reports whether the analog input is at or above the DAC level. When the conversion ends it presents a ten-bit result with a one-cycle done pulse. Between conversions the block sits idle.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `busy_o`, `done_o`, `buf_en_o` and `direct_o` are 0 and `result_o` and `dac_code_o` are zero; a reset in mid-conversion abandons it.
- R2: A `start_i` seen at a clock edge while idle begins a conversion, and `busy_o` is 1 from the next cycle; `fsel_i` and `bypass_i` count only at that edge, so later changes do not alter the conversion.
- R3: Without bypass, `buf_en_o` is high for exactly 2 conversion-clock enables; with `bypass_i`=1 at start it is never raised.
- R4: `direct_o` is high for 2, 4, 8 or 16 enables for `fsel_i` codes 00, 01, 10 and 11.
- R5: Within a conversion the phases are buffered sample, then direct sample, then resolution: the two strobes are never both high, neither is high outside `busy_o`, and no phase is revisited.
- R6: Resolution takes 10 enables. It works MSB first: each trial bit is set in `dac_code_o` and, at the next enable, kept when `cmp_hi_i`=1 (input at or above the DAC code) or cleared otherwise. With an ideal comparator, `result_o` equals the analog value.
- R7: A conversion lasts 14 to 28 enables without bypass and 12 to 26 with it (2 + final length + 10, minus 2 when bypassed).
- R8: `done_o` is a single-cycle pulse in the cycle `busy_o` falls. `result_o` changes only together with a done pulse and holds otherwise.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored: the running conversion keeps its length and result.
- R10: Phase state and `dac_code_o` advance only at edges where `conv_en_i` is 1; with the enable held low a busy sequencer holds still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| conv_en_i | input | 1 | One-cycle conversion-clock enable from the prescaler |
| start_i | input | 1 | Start request pulse |
| fsel_i | input | 2 | Final-sample length code: 00=2, 01=4, 10=8, 11=16 enables |
| bypass_i | input | 1 | Skip the buffered sample phase |
| cmp_hi_i | input | 1 | Comparator: 1 when the analog input is at or above the DAC code |
| busy_o | output | 1 | Conversion in progress |
| buf_en_o | output | 1 | Buffer amplifier drives the sample capacitor |
| direct_o | output | 1 | Input drives the capacitor array directly, amplifier bypassed |
| dac_code_o | output | 10 | Trial code for the capacitor-array DAC |
| result_o | output | 10 | Last completed conversion result |
| done_o | output | 1 | One-cycle pulse when a result is delivered |

## Verification
The bound checker watches, on every cycle, the ordering and exclusivity of the two sampling strobes. It also checks that a busy sequencer freezes when the enable is absent, that done is a one-cycle pulse coinciding with the fall of busy, and that the result register moves only with done. Phase lengths per select code, the effect of bypass, the correctness of the binary search against analog values, the latching of the mode inputs and the rejection of a start while busy are per-conversion properties. Only the bench's scenarios show those, by counting enables per strobe and comparing the delivered result.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INIT  = 2'd1,
    PH_FINAL = 2'd2,
    PH_RESOL = 2'd3
  } phase_e;

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int INIT_CYC = 2,
  parameter int BASE_FIN = 2,
  parameter int FSEL_W   = 2,
  localparam int MAX_FIN = BASE_FIN << ((1 << FSEL_W) - 1),
  localparam int MAX_LEN = (MAX_FIN > RES_BITS) ?
                           ((MAX_FIN > INIT_CYC) ? MAX_FIN : INIT_CYC) :
                           ((RES_BITS > INIT_CYC) ? RES_BITS : INIT_CYC),
  localparam int CNT_W   = $clog2(MAX_LEN + 1),
  localparam int IDX_W   = $clog2(RES_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_en_i,
  input  logic              start_i,
  input  logic [FSEL_W-1:0] fsel_i,
  input  logic              bypass_i,
  output phase_e            phase_o,
  output logic              clear_o,
  output logic              load_o,
  output logic              step_o,
  output logic              last_o,
  output logic [IDX_W-1:0]  bit_idx_o
);

  localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] RES_LAST  = CNT_W'(RES_BITS - 1);

  phase_e              phase_q, phase_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [FSEL_W-1:0]   sel_q, sel_n;
  logic [CNT_W-1:0]    fin_last;

  always_comb begin
    fin_last = CNT_W'((32'(BASE_FIN) << sel_q) - 32'd1);
  end

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sel_n   = sel_q;
    clear_o = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    last_o  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          clear_o = 1'b1;
          sel_n   = fsel_i;
          cnt_n   = '0;
          phase_n = bypass_i ? PH_FINAL : PH_INIT;
        end
      end
      PH_INIT: begin
        if (conv_en_i) begin
          if (cnt_q == INIT_LAST) begin
            phase_n = PH_FINAL;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      PH_FINAL: begin
        if (conv_en_i) begin
          if (cnt_q == fin_last) begin
            phase_n = PH_RESOL;
            cnt_n   = '0;
            load_o  = 1'b1;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      PH_RESOL: begin
        if (conv_en_i) begin
          step_o = 1'b1;
          if (cnt_q == RES_LAST) begin
            last_o  = 1'b1;
            phase_n = PH_IDLE;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
          end
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sel_q   <= '0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sel_q   <= sel_n;
    end
  end

  assign phase_o   = phase_q;
  assign bit_idx_o = IDX_W'(RES_BITS - 1) - IDX_W'(cnt_q);

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_BITS = 10,
  localparam int IDX_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                last_i,
  input  logic [IDX_W-1:0]    bit_idx_i,
  input  logic                cmp_hi_i,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o
);

  logic [RES_BITS-1:0] sar_q, sar_n;
  logic [RES_BITS-1:0] res_q, res_n;
  logic                done_q, done_n;

  always_comb begin
    sar_n  = sar_q;
    res_n  = res_q;
    done_n = 1'b0;
    if (clear_i) begin
      sar_n = '0;
    end
    if (load_i) begin
      sar_n               = '0;
      sar_n[RES_BITS-1]   = 1'b1;
    end
    if (step_i) begin
      sar_n[bit_idx_i] = cmp_hi_i;
      if (bit_idx_i != '0) begin
        sar_n[bit_idx_i - IDX_W'(1)] = 1'b1;
      end
      if (last_i) begin
        res_n  = sar_n;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sar_q  <= sar_n;
      res_q  <= res_n;
      done_q <= done_n;
    end
  end

  assign dac_code_o = sar_q;
  assign result_o   = res_q;
  assign done_o     = done_q;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int INIT_CYC = 2,
  parameter int BASE_FIN = 2,
  parameter int FSEL_W   = 2,
  localparam int IDX_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_en_i,
  input  logic                start_i,
  input  logic [FSEL_W-1:0]   fsel_i,
  input  logic                bypass_i,
  input  logic                cmp_hi_i,
  output logic                busy_o,
  output logic                buf_en_o,
  output logic                direct_o,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o
);

  phase_e           phase;
  logic             clear, load, step, last;
  logic [IDX_W-1:0] bit_idx;

  sar_phase_ctrl #(
    .RES_BITS (RES_BITS),
    .INIT_CYC (INIT_CYC),
    .BASE_FIN (BASE_FIN),
    .FSEL_W   (FSEL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_en_i (conv_en_i),
    .start_i   (start_i),
    .fsel_i    (fsel_i),
    .bypass_i  (bypass_i),
    .phase_o   (phase),
    .clear_o   (clear),
    .load_o    (load),
    .step_o    (step),
    .last_o    (last),
    .bit_idx_o (bit_idx)
  );

  sar_approx_reg #(
    .RES_BITS (RES_BITS)
  ) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .load_i     (load),
    .step_i     (step),
    .last_i     (last),
    .bit_idx_i  (bit_idx),
    .cmp_hi_i   (cmp_hi_i),
    .dac_code_o (dac_code_o),
    .result_o   (result_o),
    .done_o     (done_o)
  );

  assign busy_o   = (phase != PH_IDLE);
  assign buf_en_o = (phase == PH_INIT);
  assign direct_o = (phase == PH_FINAL);

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int RES_BITS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                conv_en_i,
  input logic                busy_o,
  input logic                buf_en_o,
  input logic                direct_o,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic [RES_BITS-1:0] result_o,
  input logic                done_o
);

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_en_o && direct_o)); // R5
  AST_STROBES_NEED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en_o || direct_o) |-> busy_o); // R5
  AST_INIT_THEN_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_en_o) |-> direct_o); // R5
  AST_FINAL_THEN_RESOL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(direct_o) |-> (busy_o && !buf_en_o)); // R5
  AST_FREEZE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !conv_en_i) |=> (busy_o && $stable(buf_en_o) && $stable(direct_o)
                                && $stable(dac_code_o))); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R8
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R8

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_BITS(RES_BITS)) u_chk (.*);

// File: tb/sar_conv_seq_test.sv
`timescale 1ns/1ps
module sar_conv_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_en = 1'b0;
  logic       start = 1'b0;
  logic [1:0] fsel = 2'b00;
  logic       byp = 1'b0;
  logic [9:0] ana = '0;
  logic       cmp_hi;
  logic       busy, buf_en, direct, done;
  logic [9:0] dac, result;

  int n_checks = 0;
  int n_fail   = 0;
  int div_r    = 3;
  int dcnt     = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign cmp_hi = (ana >= dac);

  always @(negedge clk) begin
    if (div_r == 0) begin
      conv_en = 1'b0;
      dcnt    = 0;
    end else if (dcnt >= div_r - 1) begin
      conv_en = 1'b1;
      dcnt    = 0;
    end else begin
      conv_en = 1'b0;
      dcnt    = dcnt + 1;
    end
  end

  sar_conv_seq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_en_i  (conv_en),
    .start_i    (start),
    .fsel_i     (fsel),
    .bypass_i   (byp),
    .cmp_hi_i   (cmp_hi),
    .busy_o     (busy),
    .buf_en_o   (buf_en),
    .direct_o   (direct),
    .dac_code_o (dac),
    .result_o   (result),
    .done_o     (done)
  );

  // {fsel, bypass, analog}
  localparam logic [12:0] VEC [8] = '{
    {2'b00, 1'b0, 10'd0},   {2'b01, 1'b0, 10'd1023},
    {2'b10, 1'b0, 10'd512}, {2'b11, 1'b0, 10'd511},
    {2'b00, 1'b1, 10'd1},   {2'b01, 1'b1, 10'd700},
    {2'b10, 1'b1, 10'd341}, {2'b11, 1'b1, 10'd682}
  };

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic convert(input logic [1:0] s, input logic b, input logic [9:0] a,
                         input bit poke);
    int n_all, n_buf, n_dir, guard, ph, ph_prev;
    bit order_bad, poked;
    logic [9:0] res_at_done;
    n_all = 0; n_buf = 0; n_dir = 0; guard = 0; ph_prev = 0;
    order_bad = 1'b0; poked = 1'b0;
    ana = a;
    fsel = s; byp = b; start = 1'b1;
    tick();
    start = 1'b0;
    fsel = ~s; byp = ~b;  // R2: later changes must not matter
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!done && guard < 2000) begin
      ph = buf_en ? 1 : direct ? 2 : busy ? 3 : 0;
      if (busy && ph < ph_prev) order_bad = 1'b1;
      if (busy) ph_prev = ph;
      if (busy && conv_en)   n_all++;
      if (buf_en && conv_en) n_buf++;
      if (direct && conv_en) n_dir++;
      if (start) start = 1'b0;
      else if (poke && !poked && n_all >= 5) begin
        start = 1'b1; fsel = ~s; byp = ~b; poked = 1'b1;  // R9
      end
      tick();
      guard++;
    end
    start = 1'b0;
    check(done == 1'b1, "R8 done reached (watchdog)", int'(done), 1);
    check(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    check(n_buf == (b ? 0 : 2), "R3 buffered sample enables", n_buf, b ? 0 : 2);
    check(n_dir == (2 << s), "R4 direct sample enables", n_dir, 2 << s);
    check(n_all == (b ? 0 : 2) + (2 << s) + 10, poke ? "R9 length with ignored start" :
          "R7 total enables", n_all, (b ? 0 : 2) + (2 << s) + 10);
    check(!order_bad, "R5 phase order", int'(order_bad), 0);
    check(result == a, poke ? "R9 result with ignored start" : "R6 result",
          int'(result), int'(a));
    res_at_done = result;
    tick();
    check(done == 1'b0, "R8 done single cycle", int'(done), 0);
    check(result == res_at_done, "R8 result held", int'(result), int'(res_at_done));
    check(busy == 1'b0, "R9 no restart from ignored start", int'(busy), 0);
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    tick();
    check(busy == 0 && done == 0 && buf_en == 0 && direct == 0, "R1 reset strobes",
          int'({busy, done, buf_en, direct}), 0);
    check(result == 0 && dac == 0, "R1 reset result", int'(result), 0);
    tick();
    rst_n = 1'b1;
    tick();
    check(busy == 0 && result == 0, "R1 idle after release", int'(result), 0);

    for (int i = 0; i < 8; i++) begin
      convert(VEC[i][12:11], VEC[i][10], VEC[i][9:0], 1'b0);
    end

    // R9: start pulse during a busy conversion
    convert(2'b10, 1'b0, 10'd613, 1'b1);

    // R10: enable held continuously, then withheld while busy
    div_r = 1;
    convert(2'b01, 1'b0, 10'd77, 1'b0);
    div_r = 5;
    ana = 10'd900; fsel = 2'b11; byp = 1'b0; start = 1'b1;
    tick();
    start = 1'b0;
    repeat (40) tick();
    div_r = 0;
    tick();
    begin
      logic [9:0] dac_hold;
      logic       dir_hold;
      dac_hold = dac; dir_hold = direct;
      repeat (20) tick();
      check(busy == 1'b1 && direct == dir_hold, "R10 phase frozen without enable",
            int'(direct), int'(dir_hold));
      check(dac == dac_hold, "R10 code frozen without enable", int'(dac), int'(dac_hold));
    end
    div_r = 2;
    begin
      int g = 0;
      while (!done && g < 500) begin tick(); g++; end
      check(result == 10'd900, "R10 resumes and completes", int'(result), 900);
    end

    // R1: reset in mid-conversion clears a nonzero result
    tick();
    ana = 10'd5; fsel = 2'b00; byp = 1'b1; start = 1'b1;
    tick();
    start = 1'b0;
    repeat (10) tick();
    rst_n = 1'b0;
    tick();
    check(busy == 0 && buf_en == 0 && direct == 0 && done == 0, "R1 mid-run reset strobes",
          int'({busy, buf_en, direct, done}), 0);
    check(result == 0 && dac == 0, "R1 mid-run reset result", int'(result), 0);
    rst_n = 1'b1;
    tick();
    check(busy == 1'b0, "R1 idle after mid-run reset", int'(busy), 0);
    convert(2'b00, 1'b1, 10'd1022, 1'b0);

    finish_run();
  end

endmodule